// File: doc/BRIEF.md
# Video Gate Control Register File

This block is the write-only control port of a bitmapped video controller. The CPU writes single bytes to it. The top two bits of each byte choose what the byte does: select a pen, load a colour into the selected entry, or update the screen mode and lower-ROM control. It keeps a palette of sixteen pens and one border entry. Each entry holds a 5-bit hardware colour number.

The pixel path takes a raw 4-bit pixel index and returns the colour of the matching pen. Before the palette is read, the index is narrowed to the number of pens the active mode provides. A new screen mode is held pending and only takes effect on a clock edge where the horizontal sync input is high, so a mode change never lands in the middle of a scan line. The lower-ROM enable is applied at once. A control byte with its interrupt bit set produces a one-cycle pulse that clears the interrupt counter elsewhere in the chip.

The RAM-banking function code is ignored by this block.

Top module: `gate_video_ctl`

## Requirements
- R1: After reset, `vid_mode` is 0, `rom_lo_en` is 1, `irq_clr` is 0, every pen and the border hold colour 0, pen 0 is selected, and no mode change is pending.
- R2: A write with data bits 7:6 = 11 (banking code) changes no output and does not change the pen selection.
- R3: A write with bits 7:6 = 00 and bit 4 = 0 selects pen bits 3:0. A following write with bits 7:6 = 01 stores bits 4:0 into that pen. The new colour appears on `pix_colour` in the cycle after the write edge, for a pixel index that addresses that pen.
- R4: A pen-select write with bit 4 = 1 selects the border whatever bits 3:0 hold. Colour writes then update `border_colour` and leave every pen unchanged.
- R5: The selection persists, so successive colour writes keep overwriting the same entry.
- R6: A write with bits 7:6 = 10 and bit 4 = 0 makes bits 1:0 the pending mode. `vid_mode` keeps its old value until a clock edge at which `hsync` is high, and takes the pending value at that edge.
- R7: The same control write sets `rom_lo_en` to the inverse of bit 2 (0 enables the lower ROM) from the cycle after the write edge, without waiting for `hsync`.
- R8: A control write with bit 4 = 1 raises `irq_clr` for exactly one cycle after the write edge. It leaves the pending mode and `rom_lo_en` untouched.
- R9: `pix_colour` is the pen addressed by `pix_idx` masked to the active mode: all 4 bits in mode 0, bits 1:0 in mode 1, bit 0 in mode 2, and bits 1:0 in mode 3.
- R10: An `hsync` edge with nothing pending leaves `vid_mode` unchanged. A control write at the same edge as `hsync` becomes pending and is applied only at a later `hsync` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one byte per cycle |
| wr_data | input | 8 | Written byte; bits 7:6 pick the function |
| hsync | input | 1 | Horizontal sync; a pending mode applies on an edge where it is high |
| pix_idx | input | 4 | Raw pixel index from the pixel shifter |
| pix_colour | output | 5 | Hardware colour of the current pixel |
| border_colour | output | 5 | Hardware colour of the border entry |
| vid_mode | output | 2 | Active screen mode |
| rom_lo_en | output | 1 | Lower ROM area enabled (level) |
| irq_clr | output | 1 | One-cycle interrupt-counter clear pulse |

## Verification
The assertions check on every cycle that the mode only moves on an edge that followed a high `hsync`. They also check that the ROM enable and border colour only change after a control or colour write, that the interrupt-clear pulse has the right cause and never lasts two cycles, and that banking writes leave the outputs alone. Only the bench scenarios can show which pen a colour lands in, that a selection persists, and that border selection ignores the low bits. They also cover the per-mode index masking, and the ordering when a control write coincides with `hsync`.

// File: rtl/gate_pkg.sv
package gate_pkg;

   typedef enum logic [1:0] {
      FN_PEN  = 2'b00,
      FN_INK  = 2'b01,
      FN_CTL  = 2'b10,
      FN_BANK = 2'b11
   } gate_fn_e;

   typedef struct packed {
      logic pen_we;
      logic ink_we;
      logic ctl_we;
      logic irq_req;
   } gate_cmd_t;

   localparam int unsigned DATA_W  = 8;
   localparam int unsigned MODE_W  = 2;
   localparam int unsigned SEL_BIT = 4;

endpackage

// File: rtl/gate_cmd_decode.sv
module gate_cmd_decode
   import gate_pkg::*;
(
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output gate_cmd_t         cmd
);

   gate_fn_e fn;

   always_comb begin
      fn          = gate_fn_e'(wr_data[DATA_W-1 -: 2]);
      cmd         = '0;
      cmd.pen_we  = wr_en && (fn == FN_PEN);
      cmd.ink_we  = wr_en && (fn == FN_INK);
      cmd.ctl_we  = wr_en && (fn == FN_CTL) && !wr_data[SEL_BIT];
      cmd.irq_req = wr_en && (fn == FN_CTL) &&  wr_data[SEL_BIT];
   end

endmodule

// File: rtl/gate_palette.sv
module gate_palette
   import gate_pkg::*;
#(
   parameter int unsigned COLOUR_W = 5,
   parameter int unsigned PEN_CNT  = 16,
   localparam int unsigned PEN_W   = $clog2(PEN_CNT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pen_we,
   input  logic                ink_we,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [MODE_W-1:0]   mode,
   input  logic [PEN_W-1:0]    pix_idx,
   output logic [COLOUR_W-1:0] pix_colour,
   output logic [COLOUR_W-1:0] border_colour
);

   localparam logic [PEN_W-1:0] MASK_ONE = PEN_W'(1);
   localparam logic [PEN_W-1:0] MASK_TWO = PEN_W'(3);
   localparam logic [PEN_W-1:0] MASK_ALL = '1;

   initial begin
      assert (COLOUR_W >= 1 && COLOUR_W <= SEL_BIT + 1)
         else $error("COLOUR_W must fit in the data field");
      assert (PEN_CNT >= 2 && PEN_CNT <= 16 && (1 << PEN_W) == PEN_CNT)
         else $error("PEN_CNT must be a power of two from 2 to 16");
   end

   logic                              sel_border;
   logic [PEN_W-1:0]                  sel_pen;
   logic [COLOUR_W-1:0]               border_q;
   logic [PEN_CNT-1:0][COLOUR_W-1:0]  ent;
   logic [PEN_W-1:0]                  idx_m;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_border <= 1'b0;
         sel_pen    <= '0;
      end else if (pen_we) begin
         sel_border <= wr_data[SEL_BIT];
         sel_pen    <= wr_data[PEN_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         border_q <= '0;
      else if (ink_we && sel_border)
         border_q <= wr_data[COLOUR_W-1:0];
   end

   for (genvar g = 0; g < PEN_CNT; g++) begin : g_pen
      logic [COLOUR_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (ink_we && !sel_border && (sel_pen == PEN_W'(g)))
            q <= wr_data[COLOUR_W-1:0];
      end
      assign ent[g] = q;
   end

   always_comb begin
      unique case (mode)
         2'd0:    idx_m = pix_idx & MASK_ALL;
         2'd2:    idx_m = pix_idx & MASK_ONE;
         default: idx_m = pix_idx & MASK_TWO;
      endcase
   end

   assign pix_colour    = ent[idx_m];
   assign border_colour = border_q;

endmodule

// File: rtl/gate_mode_ctl.sv
module gate_mode_ctl
   import gate_pkg::*;
#(
   parameter bit SYNC_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              irq_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              hsync,
   output logic [MODE_W-1:0] vid_mode,
   output logic              rom_lo_en,
   output logic              irq_clr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rom_lo_en <= 1'b1;
         irq_clr   <= 1'b0;
      end else begin
         irq_clr <= irq_req;
         if (ctl_we)
            rom_lo_en <= ~wr_data[2];
      end
   end

   if (SYNC_MODE) begin : g_sync
      logic [MODE_W-1:0] pend;
      logic              pend_v;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vid_mode <= '0;
            pend     <= '0;
            pend_v   <= 1'b0;
         end else begin
            if (hsync && pend_v) begin
               vid_mode <= pend;
               pend_v   <= 1'b0;
            end
            if (ctl_we) begin
               pend   <= wr_data[MODE_W-1:0];
               pend_v <= 1'b1;
            end
         end
      end
   end else begin : g_direct
      always_ff @(posedge clk) begin
         if (!rst_n)
            vid_mode <= '0;
         else if (ctl_we)
            vid_mode <= wr_data[MODE_W-1:0];
      end
   end

endmodule

// File: rtl/gate_video_ctl.sv
module gate_video_ctl
   import gate_pkg::*;
#(
   parameter int unsigned COLOUR_W  = 5,
   parameter int unsigned PEN_CNT   = 16,
   parameter bit          SYNC_MODE = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [7:0]                   wr_data,
   input  logic                         hsync,
   input  logic [$clog2(PEN_CNT)-1:0]   pix_idx,
   output logic [COLOUR_W-1:0]          pix_colour,
   output logic [COLOUR_W-1:0]          border_colour,
   output logic [1:0]                   vid_mode,
   output logic                         rom_lo_en,
   output logic                         irq_clr
);

   gate_cmd_t cmd;

   gate_cmd_decode u_dec (
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cmd     (cmd)
   );

   gate_palette #(
      .COLOUR_W (COLOUR_W),
      .PEN_CNT  (PEN_CNT)
   ) u_pal (
      .clk           (clk),
      .rst_n         (rst_n),
      .pen_we        (cmd.pen_we),
      .ink_we        (cmd.ink_we),
      .wr_data       (wr_data),
      .mode          (vid_mode),
      .pix_idx       (pix_idx),
      .pix_colour    (pix_colour),
      .border_colour (border_colour)
   );

   gate_mode_ctl #(
      .SYNC_MODE (SYNC_MODE)
   ) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (cmd.ctl_we),
      .irq_req   (cmd.irq_req),
      .wr_data   (wr_data),
      .hsync     (hsync),
      .vid_mode  (vid_mode),
      .rom_lo_en (rom_lo_en),
      .irq_clr   (irq_clr)
   );

endmodule

// File: rtl/gate_video_ctl_chk.sv
module gate_video_ctl_chk #(
   parameter int unsigned COLOUR_W  = 5,
   parameter bit          SYNC_MODE = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [7:0]          wr_data,
   input logic                hsync,
   input logic [COLOUR_W-1:0] border_colour,
   input logic [1:0]          vid_mode,
   input logic                rom_lo_en,
   input logic                irq_clr
);

   logic is_bank, is_ctl, is_irq, is_ink;
   assign is_bank = wr_en && (wr_data[7:6] == 2'b11);
   assign is_ctl  = wr_en && (wr_data[7:6] == 2'b10) && !wr_data[4];
   assign is_irq  = wr_en && (wr_data[7:6] == 2'b10) &&  wr_data[4];
   assign is_ink  = wr_en && (wr_data[7:6] == 2'b01);

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> !irq_clr); // R8
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |-> $past(is_irq)); // R8
   AST_MODE_AT_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (SYNC_MODE && (vid_mode != $past(vid_mode))) |-> $past(hsync)); // R6
   AST_ROM_FROM_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rom_lo_en) |-> $past(is_ctl)); // R7
   AST_BORDER_FROM_INK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(border_colour) |-> $past(is_ink)); // R4
   AST_BANK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (is_bank && !hsync) |=> ($stable(border_colour) && $stable(rom_lo_en)
                               && $stable(vid_mode) && !irq_clr)); // R2

endmodule

bind gate_video_ctl gate_video_ctl_chk #(
   .COLOUR_W  (COLOUR_W),
   .SYNC_MODE (SYNC_MODE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .hsync         (hsync),
   .border_colour (border_colour),
   .vid_mode      (vid_mode),
   .rom_lo_en     (rom_lo_en),
   .irq_clr       (irq_clr)
);

// File: tb/gate_video_ctl_bench.sv
module gate_video_ctl_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       hsync = 1'b0;
   logic [3:0] pix_idx = '0;
   logic [4:0] pix_colour, border_colour;
   logic [1:0] vid_mode;
   logic       rom_lo_en, irq_clr;

   always #(CLK_PERIOD/2) clk = ~clk;

   gate_video_ctl u_gate_video_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .hsync         (hsync),
      .pix_idx       (pix_idx),
      .pix_colour    (pix_colour),
      .border_colour (border_colour),
      .vid_mode      (vid_mode),
      .rom_lo_en     (rom_lo_en),
      .irq_clr       (irq_clr)
   );

   typedef struct {
      string tag;
      int    field;
      int    value;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   // reference model
   int   m_pal[16];
   int   m_border = 0;
   int   m_mode = 0;
   int   m_pend = 0;
   bit   m_pend_v = 1'b0;
   int   m_rom = 1;
   int   m_irq = 0;
   bit   m_selb = 1'b0;
   int   m_sel = 0;

   function automatic int masked(int idx, int mode);
      case (mode)
         0: return idx & 15;
         2: return idx & 1;
         default: return idx & 3;
      endcase
   endfunction

   task automatic push_all(string tag);
      exp_t e;
      e.tag = tag;
      e.field = 0; e.value = m_pal[masked(int'(pix_idx), m_mode)]; exp_q.push_back(e);
      e.field = 1; e.value = m_border; exp_q.push_back(e);
      e.field = 2; e.value = m_mode;   exp_q.push_back(e);
      e.field = 3; e.value = m_rom;    exp_q.push_back(e);
      e.field = 4; e.value = m_irq;    exp_q.push_back(e);
   endtask

   // one clock: optional write, hsync, pixel index; model advances at the edge
   task automatic cyc(bit we, logic [7:0] d, bit hs, logic [3:0] px, string tag);
      @(posedge clk);
      #1;
      wr_en = we; wr_data = d; hsync = hs; pix_idx = px;
      @(posedge clk);
      #1;
      wr_en = 1'b0; hsync = 1'b0;
      m_irq = 0;
      if (hs && m_pend_v) begin
         m_mode = m_pend;
         m_pend_v = 1'b0;
      end
      if (we) begin
         case (d[7:6])
            2'b00: begin m_selb = d[4]; m_sel = int'(d[3:0]); end
            2'b01: if (m_selb) m_border = int'(d[4:0]); else m_pal[m_sel] = int'(d[4:0]);
            2'b10: if (d[4]) m_irq = 1;
                   else begin m_pend = int'(d[1:0]); m_pend_v = 1'b1; m_rom = d[2] ? 0 : 1; end
            default: ;
         endcase
      end
      push_all(tag);
   endtask

   // monitor: compares pending expectations away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() != 0) begin
            exp_t e;
            int act;
            e = exp_q.pop_front();
            case (e.field)
               0: act = int'(pix_colour);
               1: act = int'(border_colour);
               2: act = int'(vid_mode);
               3: act = int'(rom_lo_en);
               default: act = int'(irq_clr);
            endcase
            total++;
            if (act !== e.value) begin
               bad++;
               $display("FAIL %s field=%0d actual=%0d expected=%0d", e.tag, e.field, act, e.value);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_pal[i] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      push_all("R1 reset");
      cyc(0, 8'h00, 0, 4'd7, "R1 reset pen");

      cyc(1, 8'h03, 0, 4'd3, "R3 select pen 3");
      cyc(1, 8'h51, 0, 4'd3, "R3 ink pen 3");
      cyc(1, 8'h47, 0, 4'd3, "R5 second ink same pen");
      cyc(1, 8'h0C, 0, 4'd12, "R3 select pen 12");
      cyc(1, 8'h5F, 0, 4'd12, "R3 ink pen 12");
      cyc(0, 8'h00, 0, 4'd3, "R5 pen 3 kept");

      cyc(1, 8'h1B, 0, 4'd11, "R4 select border");
      cyc(1, 8'h49, 0, 4'd11, "R4 ink border");
      cyc(0, 8'h00, 0, 4'd11, "R4 pen 11 untouched");

      cyc(1, 8'hC5, 0, 4'd11, "R2 bank write");
      cyc(1, 8'hFF, 0, 4'd12, "R2 bank write all ones");
      cyc(1, 8'h56, 0, 4'd11, "R2 selection kept after bank");

      cyc(1, 8'h01, 0, 4'd1, "R3 select pen 1");
      cyc(1, 8'h4D, 0, 4'd1, "R3 ink pen 1");
      cyc(1, 8'h0D, 0, 4'd13, "R3 select pen 13");
      cyc(1, 8'h42, 0, 4'd13, "R3 ink pen 13");
      cyc(1, 8'h00, 0, 4'd0, "R3 select pen 0");
      cyc(1, 8'h55, 0, 4'd0, "R3 ink pen 0");
      cyc(1, 8'h02, 0, 4'd2, "R3 select pen 2");
      cyc(1, 8'h48, 0, 4'd2, "R3 ink pen 2");
      cyc(1, 8'h0E, 0, 4'd14, "R3 select pen 14");
      cyc(1, 8'h5C, 0, 4'd14, "R3 ink pen 14");

      cyc(1, 8'h81, 0, 4'd13, "R6 mode 1 pending");
      cyc(0, 8'h00, 0, 4'd13, "R6 mode held before hsync");
      cyc(0, 8'h00, 1, 4'd13, "R6 R9 mode 1 after hsync");
      cyc(0, 8'h00, 0, 4'd14, "R9 mode 1 mask");

      cyc(1, 8'h86, 0, 4'd13, "R7 rom disabled at once");
      cyc(0, 8'h00, 1, 4'd13, "R6 R9 mode 2 after hsync");
      cyc(0, 8'h00, 0, 4'd12, "R9 mode 2 mask");

      cyc(1, 8'h93, 0, 4'd12, "R8 irq pulse high");
      cyc(0, 8'h00, 0, 4'd12, "R8 irq pulse ends");
      cyc(0, 8'h00, 1, 4'd13, "R8 R10 nothing pending at hsync");

      cyc(1, 8'h80, 1, 4'd13, "R10 write with hsync stays pending");
      cyc(0, 8'h00, 0, 4'd13, "R7 rom enabled again");
      cyc(0, 8'h00, 1, 4'd13, "R10 applied at later hsync");

      cyc(1, 8'h83, 0, 4'd14, "R6 mode 3 pending");
      cyc(0, 8'h00, 1, 4'd14, "R9 mode 3 mask");
      cyc(0, 8'h00, 0, 4'd15, "R9 mode 3 mask high index");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule